// File: doc/BRIEF.md
# Voltage Regulator Fault Supervisor

This block watches the digitized feedback of a multiphase buck regulator and decides two things every clock: whether the rail may be reported good, and what every phase's PWM stage is allowed to do. It receives the sensed output voltage, the differential output voltage, the setpoint voltage and its code, the sensed average current and its limit, two enable inputs, a supply-good flag and a soft-start-complete flag. The comparisons are done digitally on millivolt samples. The analog front end, the soft-start ramp and the modulator sit outside the block.

The power-good output qualifies the rail. It requires the soft-start to be finished, a programmable settle delay to have run out, and no undervoltage, overvoltage or overcurrent condition. Protection acts on all phases together through a 2-bit override. Overvoltage drives the phases low to discharge the output. Once the output has dropped far enough the phases are released to high impedance, and the low drive returns each time the overvoltage comes back. An overcurrent parks the phases in high impedance. Both conditions are latched until an enable input or the supply-good flag is cycled.

Top module: `vr_fault_supervisor`

## Requirements
- R1: The regulator is enabled only when `en_pwr`, `en_vtt` and `por_ok` are all 1 and `setpt_code` differs from OFF_CODE. While it is not enabled, `pgood` is 0. While it is not enabled and no overvoltage is active, every phase field of `pwm_mode` is 2'b10 (high impedance). While `por_ok` is 0, all protection state is cleared.
- R2: `pgood` becomes 1 only after PG_DELAY consecutive clock edges at which the regulator is enabled, `ss_done` is 1 and no fault or latch is present. Any interruption restarts the count.
- R3: An undervoltage is registered at the clock edge at which the regulator is enabled and 2*`vsen_mv` < `setpt_mv`. From the following cycle `pgood` is 0.
- R4: Undervoltage has hysteresis. It stays set while `vsen_mv` lies between 50% and 60% of `setpt_mv`. It clears at the edge at which 5*`vsen_mv` >= 3*`setpt_mv`. The power-good delay then starts again from zero.
- R5: The overvoltage trip level is a fixed 1275 mV until the regulator has been enabled with a valid setpoint code. From the edge after that, the level is `setpt_mv` + 175 mV. The level returns to 1275 mV when an enable input or `por_ok` falls. A change of code alone does not change it.
- R6: Whenever `por_ok` is 1 and `vdiff_mv` exceeds the trip level, every phase field is 2'b01 (forced low) in the same cycle, with no clock edge needed. This holds even while the enable inputs are low.
- R7: After an overvoltage, the phases stay forced low until `vdiff_mv` falls below the trip level minus 100 mV (`setpt_mv` + 75 mV once armed). From the next edge they are high impedance. A new crossing of the trip level forces them low again, any number of times.
- R8: The overvoltage latch prevents normal PWM (2'b00) until `en_pwr` or `en_vtt` is taken low, or `por_ok` is taken low. Changing `setpt_code`, including to OFF_CODE and back, does not clear it.
- R9: When the regulator is enabled and `iavg` > `ilim`, `pgood` is 0 in the same cycle. From the next edge the phases are latched at high impedance, with the same clearing rules as R8.
- R10: The override encoding is 2'b00 normal, 2'b01 forced low and 2'b10 high impedance. Field k of `pwm_mode` is bits [2k+1:2k], and all NPH fields always carry the same value. Any value other than 2'b00 implies `pgood` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsen_mv | input | VW | Sensed output voltage, mV |
| vdiff_mv | input | VW | Differential output voltage, mV |
| setpt_mv | input | VW | Setpoint voltage from the DAC, mV |
| setpt_code | input | CODE_W | Setpoint code, compared with OFF_CODE |
| iavg | input | VW | Sensed average phase current |
| ilim | input | VW | Overcurrent reference level |
| en_pwr | input | 1 | Power enable |
| en_vtt | input | 1 | Termination-rail enable |
| por_ok | input | 1 | Supply above power-on-reset level |
| ss_done | input | 1 | Soft-start finished |
| pgood | output | 1 | Power-good |
| pwm_mode | output | 2*NPH | Per-phase PWM override |

## Verification
The properties assume that the voltage samples and limits are held steady between clock edges. They also assume that the setpoint never exceeds 1100 mV, so that the armed trip level does not rise above the fixed 1275 mV level the forced-low property compares against. The stimulus changes every input on the falling clock edge and uses a 1000 mV setpoint with a 100-unit current limit. This keeps every sample clearly on one side of each threshold, except where a boundary is being probed on purpose, such as 600 mV for recovery and 1250 mV for the unarmed trip level.

// File: rtl/vrfs_pkg.sv
package vrfs_pkg;

  typedef enum logic [1:0] {
    PWM_RUN = 2'b00,
    PWM_LOW = 2'b01,
    PWM_HIZ = 2'b10
  } pwm_mode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_OV_LOW = 2'b01,
    ST_OV_HIZ = 2'b10,
    ST_OC_HIZ = 2'b11
  } prot_st_e;

endpackage

// File: rtl/vrfs_uv_mon.sv
module vrfs_uv_mon #(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enabled,
  input  logic [VW-1:0] vsen_mv,
  input  logic [VW-1:0] setpt_mv,
  output logic          uv_flag
);
  localparam int XW = VW + 3;

  logic [XW-1:0] vsen_x2;
  logic [XW-1:0] vsen_x5;
  logic [XW-1:0] setpt_x1;
  logic [XW-1:0] setpt_x3;
  logic          below_trip;
  logic          above_clear;
  logic          uv_q;
  logic          uv_d;
  logic          uv_en;

  always_comb begin
    vsen_x2     = XW'(vsen_mv) << 1;
    vsen_x5     = (XW'(vsen_mv) << 2) + XW'(vsen_mv);
    setpt_x1    = XW'(setpt_mv);
    setpt_x3    = (XW'(setpt_mv) << 1) + XW'(setpt_mv);
    below_trip  = vsen_x2 < setpt_x1;
    above_clear = vsen_x5 >= setpt_x3;
  end

  always_comb begin
    uv_d = uv_q;
    if (!enabled) begin
      uv_d = 1'b0;
    end else if (below_trip) begin
      uv_d = 1'b1;
    end else if (above_clear) begin
      uv_d = 1'b0;
    end
    uv_en = (uv_d != uv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q <= 1'b0;
    end else if (uv_en) begin
      uv_q <= uv_d;
    end
  end

  assign uv_flag = uv_q;

endmodule

// File: rtl/vrfs_ov_prot.sv
module vrfs_ov_prot
  import vrfs_pkg::*;
#(
  parameter int VW      = 12,
  parameter int OV_FIX  = 1275,
  parameter int OV_OFS  = 175,
  parameter int REL_OFS = 75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_ok,
  input  logic          rearm,
  input  logic          enabled,
  input  logic          oc_hit,
  input  logic [VW-1:0] vdiff_mv,
  input  logic [VW-1:0] setpt_mv,
  output logic          ov_hit,
  output prot_st_e      prot_st
);
  localparam int XW      = VW + 2;
  localparam int REL_FIX = OV_FIX - (OV_OFS - REL_OFS);

  logic [XW-1:0] trip_lvl;
  logic [XW-1:0] rel_lvl;
  logic [XW-1:0] vdiff_x;
  logic          below_rel;
  logic          seen_q;
  logic          seen_d;
  logic          seen_en;
  prot_st_e      st_q;
  prot_st_e      st_d;
  logic          st_en;

  always_comb begin
    vdiff_x = XW'(vdiff_mv);
    if (seen_q) begin
      trip_lvl = XW'(setpt_mv) + XW'(OV_OFS);
      rel_lvl  = XW'(setpt_mv) + XW'(REL_OFS);
    end else begin
      trip_lvl = XW'(OV_FIX);
      rel_lvl  = XW'(REL_FIX);
    end
    ov_hit    = por_ok && (vdiff_x > trip_lvl);
    below_rel = vdiff_x < rel_lvl;
  end

  always_comb begin
    seen_d = seen_q;
    if (!por_ok || rearm) begin
      seen_d = 1'b0;
    end else if (enabled) begin
      seen_d = 1'b1;
    end
    seen_en = (seen_d != seen_q);
  end

  always_comb begin
    st_d = st_q;
    if (!por_ok) begin
      st_d = ST_RUN;
    end else if (ov_hit) begin
      st_d = ST_OV_LOW;
    end else if (rearm) begin
      st_d = ST_RUN;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (enabled && oc_hit) begin
            st_d = ST_OC_HIZ;
          end
        end
        ST_OV_LOW: begin
          if (below_rel) begin
            st_d = ST_OV_HIZ;
          end
        end
        default: begin
          st_d = st_q;
        end
      endcase
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (seen_en) begin
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_RUN;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign prot_st = st_q;

endmodule

// File: rtl/vrfs_pg_timer.sv
module vrfs_pg_timer #(
  parameter int PG_DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic pg
);
  localparam int CW = $clog2(PG_DELAY + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(PG_DELAY);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_top;

  always_comb begin
    at_top = (cnt_q == CNT_TOP);
    cnt_d  = cnt_q;
    if (!qual) begin
      cnt_d = '0;
    end else if (!at_top) begin
      cnt_d = cnt_q + 1'b1;
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pg = qual && at_top;

endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vrfs_pkg::*;
#(
  parameter int              VW       = 12,
  parameter int              CODE_W   = 8,
  parameter int              NPH      = 4,
  parameter int              PG_DELAY = 1000,
  parameter logic [CODE_W-1:0] OFF_CODE = '1,
  parameter int              OV_FIX   = 1275,
  parameter int              OV_OFS   = 175,
  parameter int              REL_OFS  = 75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VW-1:0]     vsen_mv,
  input  logic [VW-1:0]     vdiff_mv,
  input  logic [VW-1:0]     setpt_mv,
  input  logic [CODE_W-1:0] setpt_code,
  input  logic [VW-1:0]     iavg,
  input  logic [VW-1:0]     ilim,
  input  logic              en_pwr,
  input  logic              en_vtt,
  input  logic              por_ok,
  input  logic              ss_done,
  output logic              pgood,
  output logic [2*NPH-1:0]  pwm_mode
);
  logic      code_valid;
  logic      enabled;
  logic      rearm;
  logic      oc_hit;
  logic      uv_flag;
  logic      ov_hit;
  logic      qual;
  prot_st_e  prot_st;
  pwm_mode_e mode_all;

  always_comb begin
    code_valid = (setpt_code != OFF_CODE);
    rearm      = !en_pwr || !en_vtt;
    enabled    = en_pwr && en_vtt && por_ok && code_valid;
    oc_hit     = iavg > ilim;
  end

  vrfs_uv_mon #(
    .VW(VW)
  ) u_uv (
    .clk      (clk),
    .rst_n    (rst_n),
    .enabled  (enabled),
    .vsen_mv  (vsen_mv),
    .setpt_mv (setpt_mv),
    .uv_flag  (uv_flag)
  );

  vrfs_ov_prot #(
    .VW      (VW),
    .OV_FIX  (OV_FIX),
    .OV_OFS  (OV_OFS),
    .REL_OFS (REL_OFS)
  ) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_ok   (por_ok),
    .rearm    (rearm),
    .enabled  (enabled),
    .oc_hit   (oc_hit),
    .vdiff_mv (vdiff_mv),
    .setpt_mv (setpt_mv),
    .ov_hit   (ov_hit),
    .prot_st  (prot_st)
  );

  always_comb begin
    qual = enabled && ss_done && (prot_st == ST_RUN) &&
           !uv_flag && !ov_hit && !oc_hit;
  end

  vrfs_pg_timer #(
    .PG_DELAY(PG_DELAY)
  ) u_pg (
    .clk   (clk),
    .rst_n (rst_n),
    .qual  (qual),
    .pg    (pgood)
  );

  always_comb begin
    if (ov_hit || (prot_st == ST_OV_LOW)) begin
      mode_all = PWM_LOW;
    end else if ((prot_st == ST_RUN) && enabled) begin
      mode_all = PWM_RUN;
    end else begin
      mode_all = PWM_HIZ;
    end
  end

  for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
    assign pwm_mode[2*ph +: 2] = mode_all;
  end

endmodule

// File: rtl/vrfs_chk.sv
module vrfs_chk #(
  parameter int              VW       = 12,
  parameter int              CODE_W   = 8,
  parameter int              NPH      = 4,
  parameter logic [CODE_W-1:0] OFF_CODE = '1,
  parameter int              OV_FIX   = 1275,
  parameter int              OV_OFS   = 175
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VW-1:0]     vsen_mv,
  input logic [VW-1:0]     vdiff_mv,
  input logic [VW-1:0]     setpt_mv,
  input logic [CODE_W-1:0] setpt_code,
  input logic [VW-1:0]     iavg,
  input logic [VW-1:0]     ilim,
  input logic              en_pwr,
  input logic              en_vtt,
  input logic              por_ok,
  input logic              ss_done,
  input logic              pgood,
  input logic [2*NPH-1:0]  pwm_mode
);
  localparam int XW = VW + 2;

  logic          en_all;
  logic [XW-1:0] armed_trip;
  logic          ov_both;
  logic          uv_low;

  always_comb begin
    en_all     = en_pwr && en_vtt && por_ok && (setpt_code != OFF_CODE);
    armed_trip = XW'(setpt_mv) + XW'(OV_OFS);
    ov_both    = por_ok && (XW'(vdiff_mv) > armed_trip) && (XW'(vdiff_mv) > XW'(OV_FIX));
    uv_low     = (XW'(vsen_mv) << 1) < XW'(setpt_mv);
  end

  // R2: power-good only with soft-start finished and all enables present
  p_pg_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (ss_done && en_pwr && en_vtt && por_ok));

  // R3: an undervoltage seen while enabled pulls power-good low next cycle
  p_uv_drops_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all && uv_low) |=> !pgood);

  // R1: supply flag low for two samples leaves outputs parked and pg low
  p_por_parks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok && $past(!por_ok)) |-> (!pgood && (pwm_mode[1:0] == 2'b10)));

  // R10: any override other than normal excludes power-good
  p_override_no_pg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode[1:0] != 2'b00) |-> !pgood);

  for (genvar ph = 0; ph < NPH; ph++) begin : g_ph
    // R6: overvoltage above every possible trip level forces this phase low
    p_ov_forces_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ov_both |-> (pwm_mode[2*ph +: 2] == 2'b01));

    // R9: overcurrent while enabled stops normal PWM from the next cycle
    p_oc_stops_pwm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_all && (iavg > ilim)) |=> (pwm_mode[2*ph +: 2] != 2'b00));
  end

endmodule

bind vr_fault_supervisor vrfs_chk #(
  .VW       (VW),
  .CODE_W   (CODE_W),
  .NPH      (NPH),
  .OFF_CODE (OFF_CODE),
  .OV_FIX   (OV_FIX),
  .OV_OFS   (OV_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsen_mv    (vsen_mv),
  .vdiff_mv   (vdiff_mv),
  .setpt_mv   (setpt_mv),
  .setpt_code (setpt_code),
  .iavg       (iavg),
  .ilim       (ilim),
  .en_pwr     (en_pwr),
  .en_vtt     (en_vtt),
  .por_ok     (por_ok),
  .ss_done    (ss_done),
  .pgood      (pgood),
  .pwm_mode   (pwm_mode)
);

// File: tb/sim_vr_fault_supervisor.sv
`timescale 1ns/1ps
module sim_vr_fault_supervisor;
  localparam int VW  = 12;
  localparam int CW  = 8;
  localparam int NPH = 3;
  localparam int DLY = 4;
  localparam logic [1:0] M_RUN = 2'b00;
  localparam logic [1:0] M_LOW = 2'b01;
  localparam logic [1:0] M_HIZ = 2'b10;

  logic          clk;
  logic          rst_n;
  logic [VW-1:0] vsen_mv, vdiff_mv, setpt_mv, iavg, ilim;
  logic [CW-1:0] setpt_code;
  logic          en_pwr, en_vtt, por_ok, ss_done;
  logic          pgood;
  logic [2*NPH-1:0] pwm_mode;

  typedef struct {
    logic       pg;
    logic [1:0] md;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   total;
  int   bad;
  bit   done;

  vr_fault_supervisor #(
    .VW(VW), .CODE_W(CW), .NPH(NPH), .PG_DELAY(DLY), .OFF_CODE(8'hFF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .vsen_mv(vsen_mv), .vdiff_mv(vdiff_mv),
    .setpt_mv(setpt_mv), .setpt_code(setpt_code), .iavg(iavg), .ilim(ilim),
    .en_pwr(en_pwr), .en_vtt(en_vtt), .por_ok(por_ok), .ss_done(ss_done),
    .pgood(pgood), .pwm_mode(pwm_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2*NPH-1:0] rep(input logic [1:0] m);
    logic [2*NPH-1:0] r;
    for (int k = 0; k < NPH; k++) r[2*k +: 2] = m;
    return r;
  endfunction

  task automatic compare(input logic pg, input logic [1:0] md, input string tag);
    total++;
    if (pgood !== pg || pwm_mode !== rep(md)) begin
      bad++;
      $display("FAIL %s: pgood=%0b pwm_mode=%b expected pgood=%0b pwm_mode=%b",
               tag, pgood, pwm_mode, pg, rep(md));
    end
  endtask

  // driver: one clock edge with current inputs, expectation queued
  task automatic step(input logic pg, input logic [1:0] md, input string tag);
    @(posedge clk);
    sb_q.push_back('{pg, md, tag});
    @(negedge clk);
  endtask

  // combinational check with no clock edge in between
  task automatic now_chk(input logic pg, input logic [1:0] md, input string tag);
    #2;
    compare(pg, md, tag);
  endtask

  // monitor: pops expectations after each edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compare(e.pg, e.md, e.tag);
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0;
    vsen_mv = 0; vdiff_mv = 0; setpt_mv = 1000; setpt_code = 8'h10;
    iavg = 10; ilim = 100; en_pwr = 0; en_vtt = 0; por_ok = 0; ss_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, M_HIZ, "R1 reset and supply low");

    por_ok = 1; en_pwr = 1; en_vtt = 1; vsen_mv = 1000; vdiff_mv = 1000;
    step(1'b0, M_RUN, "R10 enabled gives normal code");

    ss_done = 1;
    for (int i = 0; i < DLY - 1; i++) step(1'b0, M_RUN, "R2 delay running");
    step(1'b1, M_RUN, "R2 delay expired");

    vsen_mv = 490;
    step(1'b0, M_RUN, "R3 undervoltage");
    vsen_mv = 550;
    step(1'b0, M_RUN, "R4 hysteresis band");
    step(1'b0, M_RUN, "R4 hysteresis band held");
    vsen_mv = 600;
    step(1'b0, M_RUN, "R4 recovery edge");
    for (int i = 0; i < DLY - 1; i++) step(1'b0, M_RUN, "R4 delay restarted");
    step(1'b1, M_RUN, "R4 pg back");

    vdiff_mv = 1180;
    now_chk(1'b0, M_LOW, "R6 same-cycle forced low");
    step(1'b0, M_LOW, "R6 forced low latched");
    vdiff_mv = 1100;
    step(1'b0, M_LOW, "R7 above release");
    vdiff_mv = 1050;
    step(1'b0, M_HIZ, "R7 released to hiz");
    vdiff_mv = 1000;
    step(1'b0, M_HIZ, "R8 latch holds");
    vdiff_mv = 1180;
    now_chk(1'b0, M_LOW, "R7 recurrence");
    step(1'b0, M_LOW, "R7 recurrence latched");
    vdiff_mv = 1000;
    step(1'b0, M_HIZ, "R7 second release");

    setpt_code = 8'hFF;
    step(1'b0, M_HIZ, "R8 off code");
    setpt_code = 8'h10;
    step(1'b0, M_HIZ, "R8 code change no clear");
    step(1'b0, M_HIZ, "R8 code change no clear held");

    en_pwr = 0;
    step(1'b0, M_HIZ, "R1 en_pwr low");
    en_pwr = 1;
    step(1'b0, M_RUN, "R8 cleared by en_pwr");

    en_vtt = 0;
    step(1'b0, M_HIZ, "R1 en_vtt low");
    vdiff_mv = 1250;
    step(1'b0, M_HIZ, "R5 fixed level not crossed");
    vdiff_mv = 1300;
    now_chk(1'b0, M_LOW, "R6 ov while disabled");
    step(1'b0, M_LOW, "R6 ov while disabled latched");
    vdiff_mv = 1000;
    step(1'b0, M_HIZ, "R8 disabled below release");
    en_vtt = 1;
    step(1'b0, M_RUN, "R8 cleared by en_vtt");
    vdiff_mv = 1200;
    now_chk(1'b0, M_LOW, "R5 armed level");
    step(1'b0, M_LOW, "R5 armed level latched");
    vdiff_mv = 1000;
    step(1'b0, M_HIZ, "R7 release armed");
    en_pwr = 0;
    step(1'b0, M_HIZ, "R8 rearm");
    en_pwr = 1;
    step(1'b0, M_RUN, "R8 rearmed");

    iavg = 150;
    now_chk(1'b0, M_RUN, "R9 pg low same cycle");
    step(1'b0, M_HIZ, "R9 overcurrent hiz");
    iavg = 10;
    step(1'b0, M_HIZ, "R9 overcurrent latched");
    en_pwr = 0;
    step(1'b0, M_HIZ, "R9 clear en low");
    en_pwr = 1;
    step(1'b0, M_RUN, "R9 cleared");
    for (int i = 0; i < DLY - 2; i++) step(1'b0, M_RUN, "R2 delay after clear");
    step(1'b1, M_RUN, "R2 pg after clear");

    setpt_code = 8'hFF;
    step(1'b0, M_HIZ, "R1 off code disables");
    setpt_code = 8'h10;
    por_ok = 0;
    step(1'b0, M_HIZ, "R1 supply low");
    step(1'b0, M_HIZ, "R1 supply low held");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule